// File: doc/BRIEF.md
# Dual-Channel Interrupt Mask Controller

This block gathers level-sensitive request lines from on-chip peripherals, plus one request that firmware raises itself, and reduces them to two exception lines for the processor: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each exception line has its own channel. A channel holds an enable mask and presents a live view of the requests, the mask, and the enabled pending requests. Every peripheral line feeds both channels at the same bit position, so firmware picks the channel for each source by choosing which mask enables it.

Firmware adds mask bits by writing ones to a channel's enable register. It removes mask bits by writing ones to that channel's clear register. Neither operation disturbs bits written as zero, so independent handlers can change the mask without a read-modify-write sequence. Access uses a simple synchronous bus: an address, a write strobe and write data in the same cycle, with read data registered one clock after the address is presented. Both exception outputs are registered, which keeps combinational glitches away from the processor.

Source positions: bit 1 is the software request; bits 3 to 6 are four timers; bit 10 is the converter; bit 11 is the serial port; bit 12 is the synchronous serial link; bits 13, 14, 18 and 19 are external pins; bits 15 and 16 are the two-wire bus master and slave; bit 17 is the motor-drive trip. Bits 0, 2, 7, 8 and 9 carry no source.

Top module: `intc_dual_mask`

## Requirements
- R1: After synchronous reset, both enable masks are all zero, the software request is low, and `irq_o` and `fiq_o` are 0.
- R2: The raw register of each channel reads the live `src_req` level at bits 3 to 6 and 10 to 19 and is not latched. `src_req` bits 0, 1, 2, 7, 8 and 9 are ignored, and raw bits 2, 7, 8, 9 and 20 to 31 read 0.
- R3: Writing 1 to bit 0 of the control word at byte offset 0x20 raises the software request, which appears at bit 1 of both raw registers. Writing 0 lowers it. The control word reads back the request in bit 0.
- R4: A write to an enable register sets the mask bits written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to a clear register resets the mask bits written as 1 and leaves all other bits unchanged. A clear register always reads 0.
- R6: The status register of a channel reads, at bits 1 to 19, the raw value ANDed with that channel's enable mask.
- R7: `irq_o` is 1 exactly when the IRQ status was non-zero on the previous clock edge. It therefore follows a request change or a mask change with one clock of delay.
- R8: In the FIQ channel only, bit 0 of the raw register reads the OR of raw bits 1 to 19, and bit 0 of the status register reads the OR of status bits 1 to 19. `fiq_o` follows the FIQ status with one clock of delay, in the same way as R7. In the IRQ channel, bit 0 reads 0.
- R9: The two channels are independent. A write to one channel's enable or clear register leaves the other channel's mask unchanged.
- R10: The register map uses byte offsets. The IRQ group is at 0x00 (status), 0x04 (raw), 0x08 (enable) and 0x0C (clear). The FIQ group uses the same layout at 0x10 to 0x1C. `bus_rdata` carries the word addressed on the previous clock. Any other offset, including misaligned ones, reads 0 and ignores writes.
- R11: Mask bits 0, 2, 7, 8, 9 and 20 to 31 cannot be set. Writing all ones to an enable register reads back 0x000FFC7A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, qualifies `bus_wdata` in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| src_req | input | 20 | Level-sensitive peripheral requests at their source positions |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The hardest situation to reach from the ports is a mask change made while a source is already pending. There, the output must hold its old value for exactly one clock after the write and only then follow the new mask. To get there, the bench holds a request steady, issues a clear write, and samples `irq_o` on the two falling edges that follow. It then repeats the same timing with the request edge as the cause instead of the write. A full sweep then drives each of the twenty source positions in turn under a full IRQ mask and an empty FIQ mask. At each position it checks the raw, status and summary bits of both channels against positions computed in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register selector inside one channel group (address bits [3:2]).
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_RAW  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_CLR  = 2'd3
  } reg_sel_e;

  // Group selector (address bits [5:4]).
  typedef enum logic [1:0] {
    GRP_IRQ  = 2'd0,
    GRP_FIQ  = 2'd1,
    GRP_CTRL = 2'd2,
    GRP_NONE = 2'd3
  } grp_sel_e;

  localparam int SWI_POS = 1;
  localparam int SUM_POS = 0;

  // Positions that carry a real source (software request included).
  function automatic logic [31:0] live_src_mask(input int width);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < width) begin
        if (i == SWI_POS || (i >= 3 && i <= 6) || i >= 10) m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  // Positions driven directly by peripheral lines (software bit excluded).
  function automatic logic [31:0] hw_src_mask(input int width);
    logic [31:0] m;
    m = live_src_mask(width);
    m[SWI_POS] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/intc_src_map.sv
module intc_src_map #(
  parameter int SRC_W = 20
) (
  input  logic [SRC_W-1:0] src_req,
  input  logic             swi_req,
  output logic [SRC_W-1:0] raw_o
);
  import intc_pkg::*;

  localparam logic [31:0] HW32 = hw_src_mask(SRC_W);
  localparam logic [SRC_W-1:0] HW_M = HW32[SRC_W-1:0];

  always_comb begin
    raw_o = src_req & HW_M;
    raw_o[SWI_POS] = swi_req;
  end

endmodule

// File: rtl/intc_mask_chan.sv
module intc_mask_chan #(
  parameter int SRC_W   = 20,
  parameter bit HAS_SUM = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_in,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] raw_o,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] stat_o,
  output logic             req_o
);
  import intc_pkg::*;

  localparam logic [31:0] LV32 = live_src_mask(SRC_W);
  localparam logic [SRC_W-1:0] LIVE_M = LV32[SRC_W-1:0];

  logic [SRC_W-1:0] en_q;
  logic [SRC_W-1:0] pend;
  logic             any_raw;
  logic             any_pend;
  logic             req_q;

  // Clear dominates set when both name the same bit.
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_bits) & ~clr_bits & LIVE_M;
  end

  assign pend     = src_in & en_q & LIVE_M;
  assign any_raw  = |(src_in & LIVE_M);
  assign any_pend = |pend;

  generate
    if (HAS_SUM) begin : g_sum
      always_comb begin
        raw_o  = src_in & LIVE_M;
        stat_o = pend;
        raw_o[SUM_POS]  = any_raw;
        stat_o[SUM_POS] = any_pend;
      end
    end else begin : g_plain
      assign raw_o  = src_in & LIVE_M;
      assign stat_o = pend;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= any_pend;
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  // R4
  en_set_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_q & ~$past(en_q) & ~$past(set_bits)) == '0));

  // R5
  en_clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~en_q & $past(en_q) & ~$past(clr_bits)) == '0));

  // R7
  req_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o != '0) |=> req_o);

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(stat_o != '0));

endmodule

// File: rtl/intc_bus_dec.sv
module intc_bus_dec #(
  parameter int SRC_W  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SRC_W-1:0]  irq_set,
  output logic [SRC_W-1:0]  irq_clr,
  output logic [SRC_W-1:0]  fiq_set,
  output logic [SRC_W-1:0]  fiq_clr,
  output logic              swi_o,
  input  logic [SRC_W-1:0]  irq_raw,
  input  logic [SRC_W-1:0]  irq_en,
  input  logic [SRC_W-1:0]  irq_stat,
  input  logic [SRC_W-1:0]  fiq_raw,
  input  logic [SRC_W-1:0]  fiq_en,
  input  logic [SRC_W-1:0]  fiq_stat,
  output logic [DATA_W-1:0] rdata
);
  import intc_pkg::*;

  localparam int PAD_W = DATA_W - SRC_W;

  grp_sel_e          grp;
  reg_sel_e          sel;
  logic              aligned;
  logic              upper_zero;
  logic              hit_irq, hit_fiq, hit_ctrl;
  logic              swi_q;
  logic [SRC_W-1:0]  wbits;
  logic [SRC_W-1:0]  pick;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  assign grp        = grp_sel_e'(addr[5:4]);
  assign sel        = reg_sel_e'(addr[3:2]);
  assign aligned    = (addr[1:0] == 2'b00);
  generate
    if (ADDR_W > 6) begin : g_hi
      assign upper_zero = (addr[ADDR_W-1:6] == '0);
    end else begin : g_nohi
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit_irq  = aligned && upper_zero && (grp == GRP_IRQ);
  assign hit_fiq  = aligned && upper_zero && (grp == GRP_FIQ);
  assign hit_ctrl = aligned && upper_zero && (grp == GRP_CTRL) && (sel == SEL_STAT);

  assign wbits        = wdata[SRC_W-1:0];
  assign unused_wdata = ^wdata[DATA_W-1:SRC_W];

  assign irq_set = (wr && hit_irq && sel == SEL_EN)  ? wbits : '0;
  assign irq_clr = (wr && hit_irq && sel == SEL_CLR) ? wbits : '0;
  assign fiq_set = (wr && hit_fiq && sel == SEL_EN)  ? wbits : '0;
  assign fiq_clr = (wr && hit_fiq && sel == SEL_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst)                 swi_q <= 1'b0;
    else if (wr && hit_ctrl) swi_q <= wdata[0];
  end
  assign swi_o = swi_q;

  always_comb begin
    pick = '0;
    if (hit_irq) begin
      case (sel)
        SEL_STAT: pick = irq_stat;
        SEL_RAW:  pick = irq_raw;
        SEL_EN:   pick = irq_en;
        default:  pick = '0;
      endcase
    end else if (hit_fiq) begin
      case (sel)
        SEL_STAT: pick = fiq_stat;
        SEL_RAW:  pick = fiq_raw;
        SEL_EN:   pick = fiq_en;
        default:  pick = '0;
      endcase
    end else if (hit_ctrl) begin
      pick[0] = swi_q;
    end
    rd_next = {{PAD_W{1'b0}}, pick};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R5
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_irq && sel == SEL_CLR) |=> (rdata == '0));

endmodule

// File: rtl/intc_dual_mask.sv
module intc_dual_mask #(
  parameter int SRC_W  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_W-1:0]  src_req,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NCH = 2;

  logic             swi;
  logic [SRC_W-1:0] src_all;
  logic [SRC_W-1:0] set_v  [NCH];
  logic [SRC_W-1:0] clr_v  [NCH];
  logic [SRC_W-1:0] raw_v  [NCH];
  logic [SRC_W-1:0] en_v   [NCH];
  logic [SRC_W-1:0] stat_v [NCH];
  logic             req_v  [NCH];

  intc_src_map #(.SRC_W(SRC_W)) u_map (
    .src_req (src_req),
    .swi_req (swi),
    .raw_o   (src_all)
  );

  // Channel 0 is the normal request, channel 1 the fast one with summary bit.
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      intc_mask_chan #(.SRC_W(SRC_W), .HAS_SUM(c == 1)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_all),
        .set_bits (set_v[c]),
        .clr_bits (clr_v[c]),
        .raw_o    (raw_v[c]),
        .en_o     (en_v[c]),
        .stat_o   (stat_v[c]),
        .req_o    (req_v[c])
      );
    end
  endgenerate

  intc_bus_dec #(.SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .irq_set  (set_v[0]),
    .irq_clr  (clr_v[0]),
    .fiq_set  (set_v[1]),
    .fiq_clr  (clr_v[1]),
    .swi_o    (swi),
    .irq_raw  (raw_v[0]),
    .irq_en   (en_v[0]),
    .irq_stat (stat_v[0]),
    .fiq_raw  (raw_v[1]),
    .fiq_en   (en_v[1]),
    .fiq_stat (stat_v[1]),
    .rdata    (bus_rdata)
  );

  assign irq_o = req_v[0];
  assign fiq_o = req_v[1];

  // R9
  irq_mask_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[5:4] == 2'd1) |=> $stable(en_v[0]));

  // R9
  fiq_mask_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[5:4] == 2'd0) |=> $stable(en_v[1]));

  // R8
  fiq_summary_chk: assert property (@(posedge clk) disable iff (rst)
    stat_v[1][0] == (stat_v[1][SRC_W-1:1] != '0));

  // R8
  fiq_out_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(stat_v[1] != '0));

  // R7
  irq_out_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(stat_v[0] != '0));

endmodule

// File: tb/sim_intc_dual_mask.sv
module sim_intc_dual_mask;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [19:0] src_req = '0;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intc_dual_mask u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic bit is_hw(input int i);
    return (i >= 3 && i <= 6) || (i >= 10 && i <= 19);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] full;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h08, v); chk("R1 irq enable", v, 0);
    rd(6'h18, v); chk("R1 fiq enable", v, 0);
    rd(6'h20, v); chk("R1 swi", v, 0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 0);

    // R11 settable mask bits, computed position by position
    full = 0;
    for (int i = 0; i < 20; i++) if (is_hw(i) || i == 1) full[i] = 1'b1;
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R11 irq enable all ones", v, full);
    chk("R11 constant", v, 32'h000F_FC7A);

    // R2 R6 R7 R8 sweep of every source position, FIQ masked
    for (int i = 0; i < 20; i++) begin
      logic [31:0] e;
      e = is_hw(i) ? (32'd1 << i) : 32'd0;
      @(negedge clk); src_req = 20'd1 << i;
      rd(6'h04, v); chk($sformatf("R2 irq raw bit %0d", i), v, e);
      rd(6'h00, v); chk($sformatf("R6 irq stat bit %0d", i), v, e);
      chk($sformatf("R7 irq_o bit %0d", i), {31'b0, irq_o}, {31'b0, e != 0});
      rd(6'h14, v); chk($sformatf("R8 fiq raw bit %0d", i), v, e | {31'b0, e != 0});
      rd(6'h10, v); chk($sformatf("R8 fiq stat bit %0d", i), v, 0);
      chk($sformatf("R8 fiq_o bit %0d", i), {31'b0, fiq_o}, 0);
    end
    @(negedge clk); src_req = '0;
    rd(6'h04, v); chk("R2 raw not latched", v, 0);

    // R5 clear register
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R5 clear all", v, 0);
    rd(6'h0C, v); chk("R5 clear reads zero", v, 0);

    // R4 set only ones
    wr(6'h08, 32'h0000_0400);
    wr(6'h08, 32'h0000_1000);
    rd(6'h08, v); chk("R4 accumulate", v, 32'h0000_1400);
    wr(6'h08, 32'h0000_0000);
    rd(6'h08, v); chk("R4 zero write no effect", v, 32'h0000_1400);
    wr(6'h0C, 32'h0000_0400);
    rd(6'h08, v); chk("R5 partial clear", v, 32'h0000_1000);

    // R7 timing on request edge (enable bit 12 held)
    @(negedge clk); src_req = 20'd1 << 12;
    #1 chk("R7 not yet raised", {31'b0, irq_o}, 0);
    @(negedge clk); chk("R7 raised after one edge", {31'b0, irq_o}, 1);
    @(negedge clk); src_req = '0;
    #1 chk("R7 not yet dropped", {31'b0, irq_o}, 1);
    @(negedge clk); chk("R7 dropped after one edge", {31'b0, irq_o}, 0);

    // R7 timing on mask change with request pending
    @(negedge clk); src_req = 20'd1 << 12;
    @(negedge clk); chk("R7 pending", {31'b0, irq_o}, 1);
    wr(6'h0C, 32'h0000_1000);
    chk("R7 holds one clock after clear", {31'b0, irq_o}, 1);
    @(negedge clk); chk("R7 drops after mask", {31'b0, irq_o}, 0);
    @(negedge clk); src_req = '0;

    // R3 software request
    wr(6'h20, 32'h1);
    rd(6'h20, v); chk("R3 ctrl readback", v, 1);
    rd(6'h04, v); chk("R3 irq raw bit1", v, 32'h2);
    rd(6'h14, v); chk("R3 fiq raw bit1 plus summary", v, 32'h3);
    wr(6'h08, 32'h2);
    @(negedge clk); chk("R3 irq_o from swi", {31'b0, irq_o}, 1);
    wr(6'h20, 32'h0);
    @(negedge clk); chk("R3 swi lowered", {31'b0, irq_o}, 0);
    wr(6'h0C, 32'hFFFF_FFFF);

    // R8 R9 FIQ channel independent
    wr(6'h18, 32'h0000_2000);
    rd(6'h08, v); chk("R9 irq mask untouched", v, 0);
    @(negedge clk); src_req = 20'd1 << 13;
    rd(6'h10, v); chk("R8 fiq stat summary", v, 32'h0000_2001);
    rd(6'h00, v); chk("R9 irq stat zero", v, 0);
    chk("R8 fiq_o", {31'b0, fiq_o}, 1);
    chk("R9 irq_o low", {31'b0, irq_o}, 0);
    wr(6'h08, 32'h0000_2000);
    wr(6'h0C, 32'h0000_2000);
    rd(6'h18, v); chk("R9 fiq mask kept", v, 32'h0000_2000);
    wr(6'h1C, 32'h0000_2000);
    @(negedge clk); chk("R8 fiq_o dropped", {31'b0, fiq_o}, 0);
    @(negedge clk); src_req = '0;

    // R10 unmapped and misaligned
    wr(6'h09, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R10 misaligned write ignored", v, 0);
    wr(6'h2C, 32'hFFFF_FFFF);
    for (int a = 36; a < 64; a += 4) begin
      rd(a[5:0], v); chk($sformatf("R10 unmapped %0h", a), v, 0);
    end
    wr(6'h08, 32'h0000_0800);
    rd(6'h09, v); chk("R10 misaligned read", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule